// File: doc/BRIEF.md
# Credit-Based Link Flow Control

This block sits at one end of a point-to-point link that moves packets of 64-bit words for a single flow. Its transmit half keeps a running total of the words it has committed to the link. Before a packet starts, it compares that total with the latest valid total the far end has reported. A packet is granted only when the far buffer can take every word of it. When it cannot, the block raises back-pressure, emits an event pulse and counts the event. A grant debits the whole packet length at once, so a granted packet is never halted part-way by flow control.

Its receive half counts the words that enter the local inbound buffer. It returns the running total, not a delta, as a credit word. A credit is emitted when the unreported words reach a threshold, or when some words are unreported and an idle interval has passed since the last credit. Both counters are two bits wider than the buffer index. Differences are taken modulo that width, so wrap-around is harmless. Every credit word carries even parity. An incoming credit that fails parity is thrown away and counted, and the previous good credit stays in force.

Top module: `credit_link_fc`

## Requirements
- R1: The outgoing credit count is the cumulative number of words accepted since reset: after 4 words it reads 4, and after 4 more it reads 8.
- R2: `pkt_gnt` is high in the same cycle as `pkt_req` exactly when BUF_WORDS - ((sent - last good credit) mod 2^CNT_W) >= `pkt_len`; equality grants.
- R3: After reset both cumulative counters are zero, so a full BUF_WORDS of remote space is free (two 512-word packets are granted back to back with default parameters); status counters read 0 and no credit is emitted.
- R4: Counters are CNT_W = log2(BUF_WORDS)+2 bits wide and all comparisons stay correct after the sent count wraps past 2^CNT_W.
- R5: An incoming credit whose bits XOR to 1 is discarded: the grant decision is unchanged and `drop_cnt` increments (saturating).
- R6: Credit word layout: bits [CNT_W-1:0] cumulative count, bits [CNT_W+6:CNT_W] 7-bit flow ID, MSB an even-parity bit making the XOR of all bits 0. Outgoing credits carry FLOW_ID; good-parity incoming credits with another flow ID are ignored without counting.
- R7: `bp` is high in every cycle a request is refused; `bp_evt` pulses only in the first cycle of a refused request; `bp_cnt` counts those pulses and saturates at all ones.
- R8: A credit is emitted one cycle after the unreported word count reaches a nonzero `cfg_thresh`.
- R9: With unreported words pending, a credit is emitted once `cfg_idle` cycles have elapsed since the previous credit: a word arriving on the first cycle after a credit yields the next credit `cfg_idle`+1 cycles after that credit.
- R10: Packet lengths are 1 to 512 words; a grant debits the whole length at once, so a following request sees the reduced space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_req | input | 1 | Packet start request |
| pkt_len | input | LEN_W | Packet length in words (1..512) |
| pkt_gnt | output | 1 | Grant, same cycle as a request that fits |
| bp | output | 1 | Back-pressure: request refused this cycle |
| bp_evt | output | 1 | First cycle of a refused request |
| bp_cnt | output | EVT_W | Saturating count of back-pressure events |
| crd_in_vld | input | 1 | Incoming credit word valid |
| crd_in | input | CRD_W | Incoming credit word |
| drop_cnt | output | EVT_W | Saturating count of parity-failed credits |
| rx_word | input | 1 | One word accepted into the local inbound buffer |
| cfg_thresh | input | CNT_W | Unreported-word threshold for a credit |
| cfg_idle | input | IDLE_W | Idle cycles before a pending credit is forced |
| crd_out_vld | output | 1 | Outgoing credit valid |
| crd_out | output | CRD_W | Outgoing credit word |

## Verification
The in-flight invariant assumes the far end never reports more words than were sent. Under that assumption, sent minus credit never exceeds the buffer size. The bench keeps to it: every good-parity credit it sends for the local flow is at or below its own model of the sent total. Credits that break the rule carry bad parity or a foreign flow ID and must be dropped anyway. The parity and hold checks assume `crd_in` is stable while `crd_in_vld` is high, and the bench drives both together away from the clock edge.

// File: rtl/credit_link_fc.sv
module credit_link_fc #(
  parameter int BUF_WORDS = 1024,
  parameter int MAX_LEN = 512,
  parameter int EVT_W = 8,
  parameter int IDLE_W = 16,
  parameter logic [6:0] FLOW_ID = 7'd5,
  localparam int IDX_W = $clog2(BUF_WORDS),
  localparam int CNT_W = IDX_W + 2,
  localparam int LEN_W = $clog2(MAX_LEN) + 1,
  localparam int CRD_W = CNT_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_req,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              pkt_gnt,
  output logic              bp,
  output logic              bp_evt,
  output logic [EVT_W-1:0]  bp_cnt,
  input  logic              crd_in_vld,
  input  logic [CRD_W-1:0]  crd_in,
  output logic [EVT_W-1:0]  drop_cnt,
  input  logic              rx_word,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic [IDLE_W-1:0] cfg_idle,
  output logic              crd_out_vld,
  output logic [CRD_W-1:0]  crd_out
);

  logic [CNT_W-1:0]  sent_cnt, last_crd, inflight, room;
  logic [CNT_W-1:0]  rx_cnt, rx_rep, pend;
  logic [IDLE_W-1:0] idle_cnt;
  logic              fit, bp_q, par_bad, flow_ok, emit;

  assign inflight = sent_cnt - last_crd;
  assign room     = CNT_W'(BUF_WORDS) - inflight;
  assign fit      = room >= CNT_W'(pkt_len);
  assign pkt_gnt  = pkt_req & fit;
  assign bp       = pkt_req & ~fit;
  assign bp_evt   = bp & ~bp_q;

  assign par_bad  = ^crd_in;
  assign flow_ok  = crd_in[CNT_W+6:CNT_W] == FLOW_ID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_cnt <= '0;
      last_crd <= '0;
      bp_q     <= 1'b0;
      bp_cnt   <= '0;
      drop_cnt <= '0;
    end else begin
      bp_q <= bp;
      if (pkt_gnt) sent_cnt <= sent_cnt + CNT_W'(pkt_len);
      if (bp_evt && bp_cnt != '1) bp_cnt <= bp_cnt + 1'b1;
      if (crd_in_vld) begin
        if (par_bad) begin
          if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
        end else if (flow_ok) begin
          last_crd <= crd_in[CNT_W-1:0];
        end
      end
    end
  end

  assign pend = rx_cnt - rx_rep;
  assign emit = (pend != '0) && (pend >= cfg_thresh || idle_cnt >= cfg_idle);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt      <= '0;
      rx_rep      <= '0;
      idle_cnt    <= '0;
      crd_out_vld <= 1'b0;
      crd_out     <= '0;
    end else begin
      if (rx_word) rx_cnt <= rx_cnt + 1'b1;
      crd_out_vld <= emit;
      if (emit) begin
        rx_rep   <= rx_cnt;
        idle_cnt <= '0;
        crd_out  <= {^{FLOW_ID, rx_cnt}, FLOW_ID, rx_cnt};
      end else if (idle_cnt != '1) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R2, R4: given sane credits, in-flight words never exceed the remote buffer
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_cnt - last_crd) <= CNT_W'(BUF_WORDS));

  a_r5_bad_crd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_in_vld && par_bad) |=> $stable(last_crd));

  a_r5_drop_mono: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt >= $past(drop_cnt));

  a_r6_out_parity: assert property (@(posedge clk) disable iff (!rst_n)
    crd_out_vld |-> (^crd_out == 1'b0));

  a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_evt && pkt_req) |=> (pkt_req && !fit) |-> !bp_evt);

  a_r7_gnt_bp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_gnt && bp));

endmodule

// File: tb/test_credit_link_fc.sv
`timescale 1ns/1ps
module test_credit_link_fc;
  localparam int CW = 20;
  localparam int MOD = 4096;

  logic clk = 0, rst_n = 0;
  logic pkt_req = 0;
  logic [9:0] pkt_len = '0;
  logic pkt_gnt, bp, bp_evt, crd_out_vld;
  logic [7:0] bp_cnt, drop_cnt;
  logic crd_in_vld = 0;
  logic [CW-1:0] crd_in = '0, crd_out;
  logic rx_word = 0;
  logic [11:0] cfg_thresh = 12'd4;
  logic [15:0] cfg_idle = 16'd60000;

  int checks = 0, errors = 0;
  int sent = 0, exp_bp = 0, exp_drop = 0;

  credit_link_fc i_credit_link_fc (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input int cnt, input logic [6:0] fl, input logic bad);
    logic [18:0] p;
    p = {fl, 12'(cnt)};
    return {(^p) ^ bad, p};
  endfunction

  task automatic send_crd(input logic [CW-1:0] w);
    @(negedge clk); crd_in_vld = 1; crd_in = w;
    @(negedge clk); crd_in_vld = 0;
  endtask

  task automatic req_ok(input int len, input string tag);
    @(negedge clk); pkt_req = 1; pkt_len = 10'(len);
    #1 chk({tag, " gnt"}, pkt_gnt, 1);
    chk({tag, " bp"}, bp, 0);
    @(negedge clk); pkt_req = 0;
    sent = (sent + len) % MOD;
  endtask

  task automatic req_no(input int len, input string tag);
    @(negedge clk); pkt_req = 1; pkt_len = 10'(len);
    #1 chk({tag, " gnt"}, pkt_gnt, 0);
    chk("R7 bp level", bp, 1);
    chk("R7 bp_evt first", bp_evt, 1);
    @(negedge clk);
    chk("R7 bp_evt once", bp_evt, 0);
    chk("R7 bp held", bp, 1);
    pkt_req = 0;
    if (exp_bp < 255) exp_bp++;
    @(negedge clk);
    chk("R7 bp_cnt", bp_cnt, exp_bp);
  endtask

  task automatic t_reset;
    chk("R3 bp_cnt", bp_cnt, 0);
    chk("R3 drop_cnt", drop_cnt, 0);
    chk("R3 crd_out_vld", crd_out_vld, 0);
  endtask

  task automatic t_thresh;
    for (int k = 1; k <= 2; k++) begin
      @(negedge clk); rx_word = 1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); chk("R8 no early credit", crd_out_vld, 0);
      end
      @(negedge clk); rx_word = 0; chk("R8 not yet", crd_out_vld, 0);
      @(negedge clk);
      chk("R8 credit at threshold", crd_out_vld, 1);
      chk("R1 cumulative count", crd_out[11:0], 4 * k);
      chk("R6 flow field", crd_out[18:12], 5);
      chk("R6 parity", ^crd_out, 0);
      @(negedge clk); chk("R8 single credit", crd_out_vld, 0);
    end
  endtask

  task automatic t_idle;
    cfg_thresh = 12'd100; cfg_idle = 16'd6;
    @(negedge clk); rx_word = 1;
    @(negedge clk); rx_word = 0;
    while (!crd_out_vld) @(negedge clk);
    chk("R9 idle credit count", crd_out[11:0], 9);
    rx_word = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); rx_word = 0;
      chk("R9 waits idle interval", crd_out_vld, 0);
    end
    @(negedge clk);
    chk("R9 idle credit fires", crd_out_vld, 1);
    chk("R9 idle credit value", crd_out[11:0], 10);
    cfg_idle = 16'hFFFF;
  endtask

  task automatic t_space;
    req_ok(512, "R3 first full pkt");
    req_ok(512, "R10 second pkt");
    req_no(1, "R2 full buffer");
    send_crd(mk(1024, 7'd5, 1));
    exp_drop++;
    chk("R5 drop_cnt", drop_cnt, exp_drop);
    req_no(1, "R5 bad credit ignored");
    send_crd(mk(1024, 7'd9, 0));
    chk("R6 foreign flow not dropped", drop_cnt, exp_drop);
    req_no(1, "R6 foreign flow ignored");
    send_crd(mk(1, 7'd5, 0));
    req_ok(1, "R2 exact fit");
    req_no(1, "R10 debit seen");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 10; i++) begin
      send_crd(mk(sent, 7'd5, 0));
      req_ok(512, "R4 wrap pkt a");
      req_ok(512, "R4 wrap pkt b");
    end
    send_crd(mk((sent - 1023 + MOD) % MOD, 7'd5, 0));
    req_no(2, "R4 boundary after wrap");
    req_ok(1, "R4 last word after wrap");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); pkt_req = 1; pkt_len = 10'd1;
      @(negedge clk); pkt_req = 0;
    end
    @(negedge clk);
    chk("R7 bp_cnt saturates", bp_cnt, 255);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_thresh;
    t_idle;
    t_space;
    t_wrap;
    t_sat;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule